// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master for a three-wire serial digital-to-analog converter. A client hands it a 16-bit output code and a 2-bit power-down selection through a valid/ready handshake. The controller builds a 24-bit word from them and shifts it out most significant bit first on an active-low frame strobe, a serial clock and a serial data line. The word is six zero pad bits, then the two mode bits, then the code. The receiver samples data on the falling serial clock edge, so the controller moves data only on rising edges. This is clock polarity 0, phase 1.

The serial clock half period and the spacing between frames are parameters. Each is computed from the system clock frequency, the highest allowed serial clock rate, and two nanosecond limits. One limit is the minimum time the strobe stays high. The other is the minimum delay from the last falling clock edge to the next strobe fall. With byte mode selected at acceptance, the word goes out as three 8-bit bursts with the strobe held low throughout, and a programmable pause with the clock low separates the bursts. A receiver discards any frame cut short, so the controller never raises the strobe before the 24th falling edge unless the client asks for an abort.

Top module: `sdac_write_ctrl`

## Requirements
- R1: Each completed frame carries exactly the 24 bits {6'b000000, mode[1:0], code[15:0]} taken at acceptance. They are sent MSB first and each bit is valid on `dac_sdo` at a falling edge of `dac_sclk`.
- R2: `dac_sdo` changes only in a cycle where `dac_sclk` rises, a frame is loaded, or the strobe rises. It is constant for every cycle that `dac_sclk` stays high.
- R3: `dac_sclk` high phases last HALF_CYC system cycles, and ordinary low phases (including the first, after the strobe falls) last HALF_CYC cycles. With the default parameters HALF_CYC is 3. While `dac_sync_n` is high, `dac_sclk` and `dac_sdo` are both 0.
- R4: A completed frame has exactly 24 falling edges while `dac_sync_n` is low. `dac_sync_n` rises HALF_CYC cycles after the 24th falling edge. `frame_done` is a one-cycle pulse in the first cycle `dac_sync_n` is high after a completed frame, and at no other time.
- R5: Between frames `dac_sync_n` stays high for at least SYNC_HI_CYC cycles, which is 5 with the defaults.
- R6: A new strobe fall comes at least TAIL_CYC cycles after the previous falling clock edge, which is 10 with the defaults.
- R7: `in_ready` is 1 when idle. A request is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until GAP_CYC cycles after the strobe rises, where GAP_CYC = max(SYNC_HI_CYC-1, TAIL_CYC-HALF_CYC-1, 1), which is 6 with the defaults. Input changes after acceptance have no effect on the frame.
- R8: When `byte_mode` is 1 at acceptance, the low phase after the 8th and after the 16th falling edge lasts BYTE_GAP_CYC+HALF_CYC cycles (7 with the defaults) with `dac_sync_n` held low.
- R9: `abort_req` during a frame, before the 24th falling edge, raises `dac_sync_n` and drives `dac_sclk` and `dac_sdo` low in the next cycle. No `frame_done` follows, and the inter-frame gap of R7 still applies. When idle, `abort_req` has no effect.
- R10: After reset `dac_sync_n`=1, `dac_sclk`=0, `dac_sdo`=0, `in_ready`=1 and `frame_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request to send a frame |
| in_ready | output | 1 | Controller can accept a request |
| in_code | input | 16 | Output code for the converter |
| in_mode | input | 2 | Power-down selection sent ahead of the code |
| byte_mode | input | 1 | Send the frame as three bursts of 8 bits |
| abort_req | input | 1 | End the current frame at once without completing it |
| dac_sync_n | output | 1 | Active-low frame strobe |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data, valid at falling clock edges |
| frame_done | output | 1 | One-cycle pulse after a completed frame |

## Verification
The assertions assume that `abort_req` is raised only for single cycles. They also assume that the client never relies on a request made while `in_ready` is low. The timing properties assume that the divider and gap parameters are consistent with each other, which the package functions guarantee. The stimulus drives every input half a cycle away from the active edge, raises `in_valid` only in a cycle where `in_ready` was observed high, and scrambles the code, mode and byte selection right after acceptance. It aborts only while a frame has clock edges still to run, and once while the controller is idle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LEAD  = 3'd1,
    PH_HIGH  = 3'd2,
    PH_LOW   = 3'd3,
    PH_PAUSE = 3'd4,
    PH_TRAIL = 3'd5
  } sdac_phase_e;

  // Round-up integer division on wide operands.
  function automatic int sdac_ceil_div(input longint num, input longint den);
    return int'((num + den - 64'sd1) / den);
  endfunction

  // Number of system cycles covering a time in nanoseconds.
  function automatic int sdac_ns_to_cycles(input longint ns, input longint clk_hz);
    return sdac_ceil_div(ns * clk_hz, 64'sd1_000_000_000);
  endfunction

  // System cycles per serial clock half period, never below one.
  function automatic int sdac_half_cycles(input longint sys_hz, input longint sclk_hz);
    int h;
    h = sdac_ceil_div(sys_hz, 64'sd2 * sclk_hz);
    return (h < 1) ? 1 : h;
  endfunction

  // Idle cycles after the strobe rises before a new request may be taken.
  function automatic int sdac_gap_cycles(input int hi_cyc, input int tail_cyc, input int half);
    int g;
    g = hi_cyc - 1;
    if (tail_cyc - half - 1 > g) g = tail_cyc - half - 1;
    if (g < 1) g = 1;
    return g;
  endfunction

endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int PAD_W  = 6,
  parameter int MODE_W = 2,
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic              sdo_o
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

  logic [FRAME_W-1:0] word_q;
  logic               sdo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
    end else if (load_i) begin
      word_q <= {{PAD_W{1'b0}}, mode_i, code_i};
      sdo_q  <= 1'b0;
    end else if (clear_i) begin
      sdo_q  <= 1'b0;
    end else if (shift_i) begin
      sdo_q  <= word_q[FRAME_W-1];
      word_q <= {word_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sdo_q;

  AST_SDO_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clear_i && !shift_i) |=> $stable(sdo_o)); // R2

endmodule

// File: rtl/sdac_gap_timer.sv
module sdac_gap_timer #(
  parameter int GAP_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_set_i,
  input  logic start_i,
  output logic ready_o
);
  localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);
  localparam logic [CW-1:0] GAP_M1 = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      ready_q <= 1'b1;
    end else if (busy_set_i) begin
      ready_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      cnt_q   <= GAP_M1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q   <= 1'b0;
        ready_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ready_o = ready_q;

  AST_GAP_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !ready_o); // R7

  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_set_i |=> !ready_o); // R7

endmodule

// File: rtl/sdac_seq.sv
module sdac_seq
  import sdac_pkg::*;
#(
  parameter int HALF_CYC     = 3,
  parameter int BYTE_GAP_CYC = 4,
  parameter int FRAME_W      = 24,
  parameter int BYTE_W       = 8,
  parameter int SYNC_HI_CYC  = 5,
  parameter int TAIL_CYC     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic abort_i,
  input  logic byte_mode_i,
  output logic sync_n_o,
  output logic sclk_o,
  output logic done_o,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic gap_start_o
);
  localparam int NF_W   = $clog2(FRAME_W + 1);
  localparam int PC_MAX = (HALF_CYC > BYTE_GAP_CYC) ? HALF_CYC : BYTE_GAP_CYC;
  localparam int PC_W   = (PC_MAX < 2) ? 1 : $clog2(PC_MAX);
  localparam logic [PC_W-1:0] HALF_M1  = PC_W'(HALF_CYC - 1);
  localparam logic [PC_W-1:0] PAUSE_M1 = PC_W'((BYTE_GAP_CYC > 0) ? BYTE_GAP_CYC - 1 : 0);
  localparam logic [NF_W-1:0] NF_LAST  = NF_W'(FRAME_W);
  localparam logic [NF_W-1:0] NF_BYTE  = NF_W'(BYTE_W);
  localparam bit HAS_PAUSE = (BYTE_GAP_CYC > 0);

  sdac_phase_e     ph_q, ph_d;
  logic [PC_W-1:0] cnt_q, cnt_d;
  logic [NF_W-1:0] nf_q, nf_d, nf_inc;
  logic            sclk_q, sclk_d;
  logic            sync_q, sync_d;
  logic            done_q, done_d;
  logic            bm_q, bm_d;

  // Named events for the checks below.
  logic fall_evt;
  logic rise_evt;
  logic abortable;
  logic byte_edge;

  assign nf_inc    = nf_q + 1'b1;
  assign abortable = (ph_q == PH_LEAD) || (ph_q == PH_HIGH) ||
                     (ph_q == PH_LOW)  || (ph_q == PH_PAUSE);
  assign byte_edge = bm_q && ((nf_inc % NF_BYTE) == '0);

  always_comb begin
    ph_d = ph_q;   cnt_d = cnt_q;   nf_d = nf_q;
    sclk_d = sclk_q; sync_d = sync_q; done_d = 1'b0; bm_d = bm_q;
    load_o = 1'b0; shift_o = 1'b0; clear_o = 1'b0; gap_start_o = 1'b0;
    fall_evt = 1'b0; rise_evt = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (accept_i) begin
          ph_d = PH_LEAD; cnt_d = HALF_M1; nf_d = '0;
          sync_d = 1'b0; sclk_d = 1'b0; bm_d = byte_mode_i; load_o = 1'b1;
        end
      end
      PH_LEAD, PH_LOW: begin
        if (cnt_q == '0) begin
          ph_d = PH_HIGH; cnt_d = HALF_M1; sclk_d = 1'b1;
          shift_o = 1'b1; rise_evt = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin
          sclk_d = 1'b0; fall_evt = 1'b1; nf_d = nf_inc; cnt_d = HALF_M1;
          if (nf_inc == NF_LAST) begin
            ph_d = PH_TRAIL;
          end else if (byte_edge && HAS_PAUSE) begin
            ph_d = PH_PAUSE; cnt_d = PAUSE_M1;
          end else begin
            ph_d = PH_LOW;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PAUSE: begin
        if (cnt_q == '0) begin
          ph_d = PH_LOW; cnt_d = HALF_M1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TRAIL: begin
        if (cnt_q == '0) begin
          ph_d = PH_IDLE; sync_d = 1'b1; done_d = 1'b1;
          clear_o = 1'b1; gap_start_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (abortable && abort_i) begin
      ph_d = PH_IDLE; sync_d = 1'b1; sclk_d = 1'b0; done_d = 1'b0; nf_d = nf_q;
      shift_o = 1'b0; rise_evt = 1'b0; fall_evt = 1'b0;
      clear_o = 1'b1; gap_start_o = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; cnt_q <= '0; nf_q <= '0;
      sclk_q <= 1'b0; sync_q <= 1'b1; done_q <= 1'b0; bm_q <= 1'b0;
    end else begin
      ph_q <= ph_d; cnt_q <= cnt_d; nf_q <= nf_d;
      sclk_q <= sclk_d; sync_q <= sync_d; done_q <= done_d; bm_q <= bm_d;
    end
  end

  assign sync_n_o = sync_q;
  assign sclk_o   = sclk_q;
  assign done_o   = done_q;

  // Checker support: time since strobe rose and since the last falling edge.
  localparam int CK_W = $clog2(SYNC_HI_CYC + TAIL_CYC + 2) + 1;
  logic [CK_W-1:0] hi_cnt_q, tail_cnt_q;
  logic            armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0; tail_cnt_q <= '1; armed_q <= 1'b0;
    end else begin
      if (!sync_q)               hi_cnt_q <= '0;
      else if (hi_cnt_q != '1)   hi_cnt_q <= hi_cnt_q + 1'b1;
      if (fall_evt)              tail_cnt_q <= '0;
      else if (tail_cnt_q != '1) tail_cnt_q <= tail_cnt_q + 1'b1;
      if (gap_start_o)           armed_q <= 1'b1;
    end
  end

  AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_o |-> !sclk_o); // R3

  AST_FALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> (nf_q < NF_LAST)); // R4

  AST_DONE_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sync_n_o && nf_q == NF_LAST)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4

  AST_SYNC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(sync_n_o)) |-> (hi_cnt_q >= CK_W'(SYNC_HI_CYC))); // R5

  AST_TAIL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(sync_n_o)) |-> (tail_cnt_q >= CK_W'(TAIL_CYC))); // R6

  AST_PAUSE_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PAUSE) |-> (bm_q && !sclk_o && !sync_n_o)); // R8

  AST_ABORT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && abortable) |=> (sync_n_o && !sclk_o && !done_o)); // R9

  AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !sync_n_o); // R3

endmodule

// File: rtl/sdac_write_ctrl.sv
module sdac_write_ctrl
  import sdac_pkg::*;
#(
  parameter int SYS_CLK_HZ      = 100_000_000,
  parameter int SCLK_MAX_HZ     = 20_000_000,
  parameter int SYNC_HIGH_NS    = 50,
  parameter int FALL_TO_SYNC_NS = 100,
  parameter int BYTE_GAP_CYC    = 4,
  parameter int PAD_W           = 6,
  parameter int MODE_W          = 2,
  parameter int CODE_W          = 16,
  parameter int BYTE_W          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              byte_mode,
  input  logic              abort_req,
  output logic              dac_sync_n,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              frame_done
);
  localparam int FRAME_W     = PAD_W + MODE_W + CODE_W;
  localparam int HALF_CYC    = sdac_half_cycles(SYS_CLK_HZ, SCLK_MAX_HZ);
  localparam int SYNC_HI_CYC = sdac_ns_to_cycles(SYNC_HIGH_NS, SYS_CLK_HZ);
  localparam int TAIL_CYC    = sdac_ns_to_cycles(FALL_TO_SYNC_NS, SYS_CLK_HZ);
  localparam int GAP_CYC     = sdac_gap_cycles(SYNC_HI_CYC, TAIL_CYC, HALF_CYC);

  logic accept;
  logic load, shift, clear, gap_start;

  assign accept = in_valid && in_ready;

  sdac_seq #(
    .HALF_CYC     (HALF_CYC),
    .BYTE_GAP_CYC (BYTE_GAP_CYC),
    .FRAME_W      (FRAME_W),
    .BYTE_W       (BYTE_W),
    .SYNC_HI_CYC  (SYNC_HI_CYC),
    .TAIL_CYC     (TAIL_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .abort_i     (abort_req),
    .byte_mode_i (byte_mode),
    .sync_n_o    (dac_sync_n),
    .sclk_o      (dac_sclk),
    .done_o      (frame_done),
    .load_o      (load),
    .shift_o     (shift),
    .clear_o     (clear),
    .gap_start_o (gap_start)
  );

  sdac_shifter #(
    .PAD_W  (PAD_W),
    .MODE_W (MODE_W),
    .CODE_W (CODE_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .mode_i  (in_mode),
    .code_i  (in_code),
    .shift_i (shift),
    .clear_i (clear),
    .sdo_o   (dac_sdo)
  );

  sdac_gap_timer #(
    .GAP_CYC (GAP_CYC)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_set_i (accept),
    .start_i    (gap_start),
    .ready_o    (in_ready)
  );

  AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync_n |-> !dac_sdo); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_sync_n |-> !in_ready); // R7

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdo)); // R2

  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $rose(dac_sync_n)); // R4

endmodule

// File: tb/sdac_write_ctrl_tb.sv
module sdac_write_ctrl_tb;
  // Timing restated from the requirements: 10 ns system period, 20 MHz max serial clock.
  localparam int SYS_NS  = 10;
  localparam int H       = ((1_000_000_000 / 20_000_000) / 2 + SYS_NS - 1) / SYS_NS; // 3
  localparam int SYNC_HI = (50 + SYS_NS - 1) / SYS_NS;                                 // 5
  localparam int TAIL    = (100 + SYS_NS - 1) / SYS_NS;                                // 10
  localparam int GAP     = (SYNC_HI - 1 > TAIL - H - 1) ? SYNC_HI - 1 : TAIL - H - 1;  // 6
  localparam int BG      = 4;

  // {byte_mode, mode[1:0], code[15:0]}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b0, 2'd0, 16'h0000}, {1'b0, 2'd0, 16'hFFFF},
    {1'b0, 2'd1, 16'hA5C3}, {1'b0, 2'd2, 16'h8000},
    {1'b0, 2'd3, 16'h7FFF}, {1'b1, 2'd0, 16'h1234},
    {1'b1, 2'd3, 16'hFFFF}, {1'b1, 2'd1, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_code = '0;
  logic [1:0]  in_mode = '0;
  logic        byte_mode = 1'b0;
  logic        abort_req = 1'b0;
  logic        dac_sync_n, dac_sclk, dac_sdo, frame_done;

  always #5 clk = ~clk;

  sdac_write_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_mode(in_mode), .byte_mode(byte_mode),
    .abort_req(abort_req), .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk),
    .dac_sdo(dac_sdo), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Expected frames, filled in by the stimulus.
  logic [23:0] exp_word  [0:31];
  logic        exp_bm    [0:31];
  logic        exp_abort [0:31];
  int n_sent = 0;

  // Receiver model and timing monitor.
  bit          mon_en = 1'b0;
  logic        p_sync = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_ready = 1'b1;
  int          cyc = 0, t_rise = 0, t_fall = 0, fr_idx = 0;
  int          nf = 0, lo_run = 0, hi_run = 0, exp_lo = 0;
  bit          have_prev = 1'b0;
  logic [23:0] cap = '0;
  bit          bad_ready, bad_lo, bad_hi, bad_byte, bad_stable;
  bit          bad_idle = 1'b0, bad_done = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (p_sync && !dac_sync_n) begin
        if (have_prev) begin
          chk(cyc - t_rise >= SYNC_HI, "R5 strobe high time", cyc - t_rise, SYNC_HI);
          chk(cyc - t_fall >= TAIL, "R6 last fall to strobe fall", cyc - t_fall, TAIL);
        end
        nf = 0; cap = '0; lo_run = 0; hi_run = 0;
        bad_ready = 0; bad_lo = 0; bad_hi = 0; bad_byte = 0; bad_stable = 0;
      end
      if (!dac_sync_n) begin
        if (in_ready) bad_ready = 1;
        if (dac_sclk) begin
          if (!p_sclk) begin
            exp_lo = (exp_bm[fr_idx] && (nf == 8 || nf == 16)) ? BG + H : H;
            if (lo_run != exp_lo) begin
              if (exp_bm[fr_idx] && (nf == 8 || nf == 16)) bad_byte = 1;
              else bad_lo = 1;
            end
            hi_run = 0;
          end else if (dac_sdo != p_sdo) begin
            bad_stable = 1;
          end
          hi_run++;
        end else begin
          if (p_sclk) begin
            cap = {cap[22:0], dac_sdo};
            nf++;
            t_fall = cyc;
            if (hi_run != H) bad_hi = 1;
            lo_run = 0;
          end
          lo_run++;
        end
      end else if (dac_sclk || dac_sdo) begin
        bad_idle = 1;
      end
      if (!p_sync && dac_sync_n) begin
        if (exp_abort[fr_idx]) begin
          chk(nf < 24, "R9 aborted frame cut short", nf, 24);
          chk(frame_done == 1'b0, "R9 no done after abort", frame_done, 0);
        end else begin
          chk(nf == 24, "R4 falling edge count", nf, 24);
          chk(cap == exp_word[fr_idx], "R1 frame content", cap, exp_word[fr_idx]);
          chk(frame_done == 1'b1, "R4 done with strobe rise", frame_done, 1);
          chk(cyc - t_fall == H, "R4 strobe rise delay", cyc - t_fall, H);
          chk(!bad_stable, "R2 data stable while clock high", bad_stable, 0);
          if (exp_bm[fr_idx]) chk(!bad_byte, "R8 byte pause width", bad_byte, 0);
        end
        chk(!bad_hi && !bad_lo, "R3 clock phase widths", {bad_hi, bad_lo}, 0);
        chk(!bad_ready, "R7 ready low in frame", bad_ready, 0);
        t_rise = cyc;
        have_prev = 1'b1;
        fr_idx++;
      end
      if (frame_done && !(!p_sync && dac_sync_n)) bad_done = 1;
      if (!p_ready && in_ready && have_prev)
        chk(cyc - t_rise == GAP, "R7 ready return delay", cyc - t_rise, GAP);
      p_sync = dac_sync_n; p_sclk = dac_sclk; p_sdo = dac_sdo; p_ready = in_ready;
    end
  end

  task automatic send(input logic [15:0] code, input logic [1:0] mode,
                      input logic bm, input logic will_abort);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_word[n_sent]  = {6'b000000, mode, code};
    exp_bm[n_sent]    = bm;
    exp_abort[n_sent] = will_abort;
    n_sent++;
    in_valid = 1'b1; in_code = code; in_mode = mode; byte_mode = bm;
    @(negedge clk);
    // R7: scramble inputs after acceptance; the frame must not change.
    in_valid = 1'b0; in_code = ~code; in_mode = ~mode; byte_mode = ~bm;
  endtask

  task automatic wait_all();
    while (fr_idx != n_sent || !in_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", fr_idx, n_sent);
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(dac_sync_n == 1'b1, "R10 strobe after reset", dac_sync_n, 1);
    chk(dac_sclk == 1'b0, "R10 clock after reset", dac_sclk, 0);
    chk(dac_sdo == 1'b0, "R10 data after reset", dac_sdo, 0);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    chk(frame_done == 1'b0, "R10 done after reset", frame_done, 0);

    // Vector table, sent back to back to hit the minimum gaps (R5, R6, R8).
    for (int i = 0; i < 8; i++) send(VEC[i][15:0], VEC[i][17:16], VEC[i][18], 1'b0);
    wait_all();

    // R9: abort in the middle of a frame.
    send(16'hBEEF, 2'd2, 1'b0, 1'b1);
    while (nf < 5) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(dac_sync_n == 1'b1, "R9 strobe high after abort", dac_sync_n, 1);
    chk(dac_sclk == 1'b0, "R9 clock low after abort", dac_sclk, 0);
    chk(dac_sdo == 1'b0, "R9 data low after abort", dac_sdo, 0);
    chk(in_ready == 1'b0, "R9 gap kept after abort", in_ready, 0);
    wait_all();

    // R9: abort while idle has no effect.
    @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    chk(dac_sync_n == 1'b1 && in_ready == 1'b1, "R9 idle abort ignored",
        {dac_sync_n, in_ready}, 2'b11);

    // Frame right after an abort, then a byte-mode frame.
    send(16'h5A5A, 2'd1, 1'b0, 1'b0);
    send(16'hC001, 2'd2, 1'b1, 1'b0);
    wait_all();
    repeat (4) @(negedge clk);

    chk(!bad_done, "R4 done only at frame end", bad_done, 0);
    chk(!bad_idle, "R3 lines low while strobe high", bad_idle, 0);
    chk(fr_idx == n_sent, "R1 all frames seen", fr_idx, n_sent);
    report();
    $finish;
  end

endmodule